// File: doc/BRIEF.md
# Retire-Stage Precise Exception Controller

This block sits at the retire end of a reorder buffer and watches the oldest entry. A finished entry with no fault is accepted. The block then advances the committed PC, and it updates the stack pointer and flags when that entry writes them. A faulting micro-op does not produce a normal result. The block records it as the entry's outcome: a fault flag, a cause code, the faulting address and the kind of access. The block acts on a fault only when the entry reaches the head. No older fault can still be pending at that point, so the block never searches backwards through the queue.

When the head entry carries a fault, the controller runs a fixed sequence:

1. It raises one flush pulse that cancels every in-flight micro-op, the faulting one included, and holds fetch stalled.
2. It copies the committed state and the fault details into a small bank of privileged save registers.
3. It loads a handler PC and a handler stack pointer, both derived from the cause code, and switches to supervisor mode.
4. It presents the handler PC on the redirect port and releases the fetch stall in that same cycle.

A return-from-exception request from decode uses the same flush and redirect path. The block stalls fetch and waits until the reorder buffer has drained. It then restores PC, stack pointer, flags and mode from the save registers.

Top module: `retire_trap_ctrl`

## Requirements
- R1: After reset the committed PC equals the RESET_PC parameter, the stack pointer and flags are zero, the mode is supervisor (1), and all save registers read zero. Flush, fetch_halt, redir_valid and retire_ack are low.
- R2: While idle, a head entry that is valid, done and not faulting drives retire_ack high in the same cycle. From the next cycle, cur_pc equals head_next_pc. cur_sp and cur_flags take the head values only when their write enables are set.
- R3: While idle, a head entry that is invalid or not done leaves retire_ack low and changes no committed state.
- R4: While idle, a valid, done and faulting head entry is never acknowledged. In the next cycle flush is high and fetch_halt is high, and flush lasts exactly one cycle.
- R5: On a fault the save registers capture the following, each selected by its index on csr_sel: 0 the faulting head PC, 1 the committed SP, 2 the committed flags, 3 the prior mode, 4 the cause, 5 the fault address, 6 the access kind (0 read, 1 write, 2 execute). Narrower fields are zero-extended.
- R6: On a fault the committed PC becomes VEC_BASE + cause*VEC_STRIDE and the committed SP becomes KSTK_TOP - cause*KSTK_STRIDE. The mode becomes supervisor (1). One cycle after the flush, redir_valid is high with that PC on redir_pc, and fetch_halt is low in that same cycle.
- R7: While the controller is flushing, redirecting or waiting for a drain, head entries are ignored. A fault in a younger entry neither acknowledges nor starts a second fault sequence, and the saved cause is unchanged.
- R8: A rfe_req while idle raises fetch_halt in the next cycle and holds it, with no flush, while rob_empty is low. In the cycle after rob_empty is seen high, PC, SP, flags and mode are restored from save registers 0 to 3 and flush is high. In the cycle after that, redir_pc shows the restored PC and redir_valid is high.
- R9: With csr_we high, csr_wdata is written to the save register that csr_sel selects. A fault capture in the same cycle takes priority over that write.
- R10: When a faulting head and rfe_req arrive in the same idle cycle, the fault is taken and the return request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_valid | input | 1 | Retire-head entry present |
| head_done | input | 1 | Retire-head entry finished |
| head_except | input | 1 | Retire-head entry carries a fault |
| head_cause | input | CW | Fault cause code |
| head_pc | input | XW | PC of the head instruction |
| head_next_pc | input | XW | PC following the head instruction |
| head_sp_we | input | 1 | Head entry writes the stack pointer |
| head_sp_val | input | XW | Stack pointer value written |
| head_flags_we | input | 1 | Head entry writes the flags |
| head_flags_val | input | FW | Flags value written |
| head_fault_addr | input | XW | Faulting data or fetch address |
| head_fault_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rfe_req | input | 1 | Return-from-exception seen at decode |
| rob_empty | input | 1 | Reorder buffer holds no entries |
| csr_we | input | 1 | Save register write strobe |
| csr_sel | input | 3 | Save register index |
| csr_wdata | input | XW | Save register write data |
| csr_rdata | output | XW | Save register read data (combinational) |
| retire_ack | output | 1 | Head entry accepted and removed |
| flush | output | 1 | Cancel every in-flight micro-op |
| fetch_halt | output | 1 | Stall fetch |
| redir_valid | output | 1 | Redirect fetch to redir_pc |
| redir_pc | output | XW | New fetch PC |
| cur_pc | output | XW | Committed PC |
| cur_sp | output | XW | Committed stack pointer |
| cur_flags | output | FW | Committed flags |
| cur_mode | output | 1 | Committed mode: 0 user, 1 supervisor |

## Verification
Each result has a fixed due cycle:

- **retire_ack** is combinational. The bench checks it shortly after driving the head, before the clock edge.
- **Committed state, flush and the halt** appear one edge after the triggering head or request. The bench samples them at the following falling edge.
- **The redirect and the halt release** come one further edge later.
- **The return path** adds one edge after rob_empty rises.
- **Save registers** are read through the combinational port once the sequence has returned to idle.

The bench models the expected handler PC, stack pointer and mode from the cause and the formulas in the requirements, and it tracks the prior state across faults.

// File: rtl/trap_pkg.sv
// Package: shared types and constants for the retire-stage fault controller.
// Assumes save-register indices are fixed, since handler software decodes them.
package trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FLUSH    = 2'd1,
        ST_REDIR    = 2'd2,
        ST_RFE_WAIT = 2'd3
    } seq_state_t;

    localparam int SR_SELW  = 3;
    localparam int SR_COUNT = 7;

    localparam int SR_EPC    = 0;
    localparam int SR_ESP    = 1;
    localparam int SR_EFLAGS = 2;
    localparam int SR_EMODE  = 3;
    localparam int SR_ECAUSE = 4;
    localparam int SR_EADDR  = 5;
    localparam int SR_EACC   = 6;

    localparam logic MODE_USER = 1'b0;
    localparam logic MODE_SUP  = 1'b1;

endpackage

// File: rtl/trap_vector_lut.sv
// Module: trap_vector_lut
// Maps a cause code to the handler entry PC and handler stack pointer.
// Assumes handlers sit on a fixed stride above VEC_BASE and each cause owns
// its own stack slice growing down from KSTK_TOP.
module trap_vector_lut #(
    parameter int          XW          = 32,
    parameter int          CW          = 4,
    parameter int unsigned VEC_BASE    = 32'h0000_1000,
    parameter int unsigned VEC_STRIDE  = 32'h0000_0040,
    parameter int unsigned KSTK_TOP    = 32'h000F_0000,
    parameter int unsigned KSTK_STRIDE = 32'h0000_0100
) (
    input  logic [CW-1:0] cause,
    output logic [XW-1:0] handler_pc,
    output logic [XW-1:0] handler_sp
);

    logic [XW-1:0] cause_ext;

    // Purpose: widen the cause and compute both handler values.
    always_comb begin
        cause_ext  = XW'(cause);
        handler_pc = XW'(VEC_BASE) + cause_ext * XW'(VEC_STRIDE);
        handler_sp = XW'(KSTK_TOP) - cause_ext * XW'(KSTK_STRIDE);
    end

endmodule

// File: rtl/trap_save_regs.sv
// Module: trap_save_regs
// Privileged save-register bank. It captures the fault context on a fault,
// accepts software writes, provides a read port and supplies restore values.
// Assumes the fault capture outranks a software write in the same cycle.
module trap_save_regs
    import trap_pkg::*;
#(
    parameter int XW = 32,
    parameter int CW = 4,
    parameter int FW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [XW-1:0]      cap_pc,
    input  logic [XW-1:0]      cap_sp,
    input  logic [FW-1:0]      cap_flags,
    input  logic               cap_mode,
    input  logic [CW-1:0]      cap_cause,
    input  logic [XW-1:0]      cap_addr,
    input  logic [1:0]         cap_acc,
    input  logic               sw_we,
    input  logic [SR_SELW-1:0] sw_sel,
    input  logic [XW-1:0]      sw_wdata,
    output logic [XW-1:0]      rdata_sel,
    output logic [XW-1:0]      rst_pc,
    output logic [XW-1:0]      rst_sp,
    output logic [FW-1:0]      rst_flags,
    output logic               rst_mode
);

    logic [XW-1:0] regs    [SR_COUNT];
    logic [XW-1:0] cap_val [SR_COUNT];

    // Purpose: arrange the capture values by register index.
    always_comb begin
        cap_val[SR_EPC]    = cap_pc;
        cap_val[SR_ESP]    = cap_sp;
        cap_val[SR_EFLAGS] = XW'(cap_flags);
        cap_val[SR_EMODE]  = XW'(cap_mode);
        cap_val[SR_ECAUSE] = XW'(cap_cause);
        cap_val[SR_EADDR]  = cap_addr;
        cap_val[SR_EACC]   = XW'(cap_acc);
    end

    for (genvar i = 0; i < SR_COUNT; i++) begin : g_sr
        // Purpose: update one save register, capture first, then software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (capture) begin
                regs[i] <= cap_val[i];
            end else if (sw_we && (sw_sel == SR_SELW'(i))) begin
                regs[i] <= sw_wdata;
            end
        end
    end

    // Purpose: read port, zero for indices beyond the bank.
    always_comb begin
        rdata_sel = '0;
        for (int i = 0; i < SR_COUNT; i++) begin
            if (sw_sel == SR_SELW'(i)) rdata_sel = regs[i];
        end
    end

    // Purpose: hand restore values to the committed-state logic.
    always_comb begin
        rst_pc    = regs[SR_EPC];
        rst_sp    = regs[SR_ESP];
        rst_flags = regs[SR_EFLAGS][FW-1:0];
        rst_mode  = regs[SR_EMODE][0];
    end

endmodule

// File: rtl/trap_seq_fsm.sv
// Module: trap_seq_fsm
// Sequencer for the fault and return paths: idle, flush, redirect, drain wait.
// Assumes the head is looked at only while idle, so younger faults are
// discarded by the flush that the oldest fault starts.
module trap_seq_fsm
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_done,
    input  logic head_except,
    input  logic rfe_req,
    input  logic rob_empty,
    output logic take_trap,
    output logic take_retire,
    output logic take_restore,
    output logic flush,
    output logic fetch_halt,
    output logic redir_valid
);

    seq_state_t state_q, state_d;
    logic       idle;
    logic       head_ready;
    logic       start_rfe;

    // Purpose: decide which event the current cycle acts on.
    always_comb begin
        idle         = (state_q == ST_IDLE);
        head_ready   = head_valid && head_done;
        take_trap    = idle && head_ready && head_except;
        take_retire  = idle && head_ready && !head_except;
        start_rfe    = idle && rfe_req && !take_trap;
        take_restore = (state_q == ST_RFE_WAIT) && rob_empty;
    end

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_trap)      state_d = ST_FLUSH;
                else if (start_rfe) state_d = ST_RFE_WAIT;
            end
            ST_FLUSH:    state_d = ST_REDIR;
            ST_REDIR:    state_d = ST_IDLE;
            ST_RFE_WAIT: if (take_restore) state_d = ST_FLUSH;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: decode the outputs from the state; the halt drops at the redirect.
    always_comb begin
        flush       = (state_q == ST_FLUSH);
        redir_valid = (state_q == ST_REDIR);
        fetch_halt  = (state_q == ST_FLUSH) || (state_q == ST_RFE_WAIT);
    end

endmodule

// File: rtl/retire_trap_ctrl.sv
// Module: retire_trap_ctrl (top)
// Retire-stage precise fault controller. It holds the committed PC, SP,
// flags and mode, accepts clean head entries, and runs the fault and
// return-from-fault sequences.
// Assumes the reorder buffer removes the head when retire_ack is high and
// empties itself on flush.
module retire_trap_ctrl
    import trap_pkg::*;
#(
    parameter int          XW          = 32,
    parameter int          CW          = 4,
    parameter int          FW          = 4,
    parameter int unsigned RESET_PC    = 32'h0000_0100,
    parameter int unsigned VEC_BASE    = 32'h0000_1000,
    parameter int unsigned VEC_STRIDE  = 32'h0000_0040,
    parameter int unsigned KSTK_TOP    = 32'h000F_0000,
    parameter int unsigned KSTK_STRIDE = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               head_valid,
    input  logic               head_done,
    input  logic               head_except,
    input  logic [CW-1:0]      head_cause,
    input  logic [XW-1:0]      head_pc,
    input  logic [XW-1:0]      head_next_pc,
    input  logic               head_sp_we,
    input  logic [XW-1:0]      head_sp_val,
    input  logic               head_flags_we,
    input  logic [FW-1:0]      head_flags_val,
    input  logic [XW-1:0]      head_fault_addr,
    input  logic [1:0]         head_fault_acc,
    input  logic               rfe_req,
    input  logic               rob_empty,
    input  logic               csr_we,
    input  logic [SR_SELW-1:0] csr_sel,
    input  logic [XW-1:0]      csr_wdata,
    output logic [XW-1:0]      csr_rdata,
    output logic               retire_ack,
    output logic               flush,
    output logic               fetch_halt,
    output logic               redir_valid,
    output logic [XW-1:0]      redir_pc,
    output logic [XW-1:0]      cur_pc,
    output logic [XW-1:0]      cur_sp,
    output logic [FW-1:0]      cur_flags,
    output logic               cur_mode
);

    logic          take_trap;
    logic          take_retire;
    logic          take_restore;
    logic [XW-1:0] hdl_pc;
    logic [XW-1:0] hdl_sp;
    logic [XW-1:0] rst_pc;
    logic [XW-1:0] rst_sp;
    logic [FW-1:0] rst_flags;
    logic          rst_mode;
    logic [XW-1:0] pc_q;
    logic [XW-1:0] sp_q;
    logic [FW-1:0] flags_q;
    logic          mode_q;

    trap_seq_fsm u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_valid  (head_valid),
        .head_done   (head_done),
        .head_except (head_except),
        .rfe_req     (rfe_req),
        .rob_empty   (rob_empty),
        .take_trap   (take_trap),
        .take_retire (take_retire),
        .take_restore(take_restore),
        .flush       (flush),
        .fetch_halt  (fetch_halt),
        .redir_valid (redir_valid)
    );

    trap_vector_lut #(
        .XW         (XW),
        .CW         (CW),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE),
        .KSTK_TOP   (KSTK_TOP),
        .KSTK_STRIDE(KSTK_STRIDE)
    ) u_vec (
        .cause     (head_cause),
        .handler_pc(hdl_pc),
        .handler_sp(hdl_sp)
    );

    trap_save_regs #(
        .XW(XW),
        .CW(CW),
        .FW(FW)
    ) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take_trap),
        .cap_pc   (head_pc),
        .cap_sp   (sp_q),
        .cap_flags(flags_q),
        .cap_mode (mode_q),
        .cap_cause(head_cause),
        .cap_addr (head_fault_addr),
        .cap_acc  (head_fault_acc),
        .sw_we    (csr_we),
        .sw_sel   (csr_sel),
        .sw_wdata (csr_wdata),
        .rdata_sel(csr_rdata),
        .rst_pc   (rst_pc),
        .rst_sp   (rst_sp),
        .rst_flags(rst_flags),
        .rst_mode (rst_mode)
    );

    // Purpose: committed PC and mode; fault, then restore, then normal retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= XW'(RESET_PC);
            mode_q <= MODE_SUP;
        end else if (take_trap) begin
            pc_q   <= hdl_pc;
            mode_q <= MODE_SUP;
        end else if (take_restore) begin
            pc_q   <= rst_pc;
            mode_q <= rst_mode;
        end else if (take_retire) begin
            pc_q   <= head_next_pc;
        end
    end

    // Purpose: committed stack pointer and flags, under the same priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= '0;
            flags_q <= '0;
        end else if (take_trap) begin
            sp_q    <= hdl_sp;
        end else if (take_restore) begin
            sp_q    <= rst_sp;
            flags_q <= rst_flags;
        end else if (take_retire) begin
            if (head_sp_we)    sp_q    <= head_sp_val;
            if (head_flags_we) flags_q <= head_flags_val;
        end
    end

    // Purpose: drive the outputs; the redirect target is the committed PC.
    always_comb begin
        retire_ack = take_retire;
        redir_pc   = pc_q;
        cur_pc     = pc_q;
        cur_sp     = sp_q;
        cur_flags  = flags_q;
        cur_mode   = mode_q;
    end

endmodule

// File: rtl/retire_trap_ctrl_chk.sv
// Module: retire_trap_ctrl_chk
// Protocol checker bound to retire_trap_ctrl. It watches ports only.
module retire_trap_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic head_valid,
    input logic head_done,
    input logic head_except,
    input logic rob_empty,
    input logic retire_ack,
    input logic flush,
    input logic fetch_halt,
    input logic redir_valid,
    input logic cur_mode
);

    logic idle_trap;

    // Purpose: a faulting head while the block is neither stalled nor redirecting.
    always_comb idle_trap = !fetch_halt && !redir_valid && !flush &&
                            head_valid && head_done && head_except;

    p_ack_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ack |-> (head_valid && head_done && !head_except));

    p_trap_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle_trap |=> (flush && fetch_halt));

    p_flush_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && redir_valid));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (!fetch_halt && !flush));

    p_sup_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_trap |=> cur_mode);

    p_busy_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || fetch_halt || redir_valid) |-> !retire_ack);

    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_halt && !flush && !rob_empty) |=> (fetch_halt && !flush));

endmodule

bind retire_trap_ctrl retire_trap_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .head_done  (head_done),
    .head_except(head_except),
    .rob_empty  (rob_empty),
    .retire_ack (retire_ack),
    .flush      (flush),
    .fetch_halt (fetch_halt),
    .redir_valid(redir_valid),
    .cur_mode   (cur_mode)
);

// File: tb/test_retire_trap_ctrl.sv
module test_retire_trap_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_valid = 1'b0, head_done = 1'b0, head_except = 1'b0;
    logic [3:0]  head_cause = '0;
    logic [31:0] head_pc = '0, head_next_pc = '0, head_sp_val = '0, head_fault_addr = '0;
    logic        head_sp_we = 1'b0, head_flags_we = 1'b0;
    logic [3:0]  head_flags_val = '0;
    logic [1:0]  head_fault_acc = '0;
    logic        rfe_req = 1'b0, rob_empty = 1'b1, csr_we = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata, redir_pc, cur_pc, cur_sp;
    logic [3:0]  cur_flags;
    logic        retire_ack, flush, fetch_halt, redir_valid, cur_mode;

    int n_chk = 0;
    int n_fail = 0;

    // Fault vectors: {cause, pc, address, access, rfe in same cycle}
    localparam logic [70:0] TV [4] = '{
        {4'd3,  32'h0000_2000, 32'hDEAD_0000, 2'd1, 1'b0},
        {4'd0,  32'h0000_1004, 32'h0000_0000, 2'd2, 1'b1},
        {4'd15, 32'h0000_1C08, 32'h1234_5678, 2'd0, 1'b0},
        {4'd7,  32'h0000_3330, 32'hCAFE_0004, 2'd1, 1'b0}
    };

    retire_trap_ctrl #(
        .XW(32), .CW(4), .FW(4), .RESET_PC(32'h100),
        .VEC_BASE(32'h1000), .VEC_STRIDE(32'h40),
        .KSTK_TOP(32'hF0000), .KSTK_STRIDE(32'h100)
    ) i_retire_trap_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_csr(input logic [2:0] sel, output logic [31:0] val);
        csr_sel = sel;
        #1;
        val = csr_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_sp, exp_pc;
        logic [3:0]  exp_flags;
        logic        exp_mode;
        repeat (2) step();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "cur_pc", cur_pc, 32'h100);
        check("R1", "cur_mode", {31'd0, cur_mode}, 32'd1);
        check("R1", "cur_sp", cur_sp, 32'd0);
        check("R1", "outputs", {28'd0, flush, fetch_halt, redir_valid, retire_ack}, 32'd0);
        rd_csr(3'd4, v);
        check("R1", "ecause", v, 32'd0);

        // R2 normal retire
        head_valid = 1; head_done = 1; head_next_pc = 32'h200;
        head_sp_we = 1; head_sp_val = 32'h8000; head_flags_we = 1; head_flags_val = 4'h5;
        #1;
        check("R2", "ack", {31'd0, retire_ack}, 32'd1);
        step();
        check("R2", "cur_pc", cur_pc, 32'h200);
        check("R2", "cur_sp", cur_sp, 32'h8000);
        check("R2", "cur_flags", {28'd0, cur_flags}, 32'h5);
        head_next_pc = 32'h204; head_sp_we = 0; head_flags_we = 0; head_sp_val = 32'h1;
        step();
        check("R2", "sp kept without we", cur_sp, 32'h8000);

        // R3 not-done head
        head_done = 0; head_next_pc = 32'h999;
        #1;
        check("R3", "no ack", {31'd0, retire_ack}, 32'd0);
        step();
        check("R3", "pc unchanged", cur_pc, 32'h204);
        head_valid = 0;

        // R9 software writes of save registers
        csr_we = 1;
        csr_sel = 3'd0; csr_wdata = 32'h2000; step();
        csr_sel = 3'd1; csr_wdata = 32'h7000; step();
        csr_sel = 3'd2; csr_wdata = 32'h3;    step();
        csr_sel = 3'd3; csr_wdata = 32'h0;    step();
        csr_we = 0;
        rd_csr(3'd0, v); check("R9", "epc write", v, 32'h2000);
        rd_csr(3'd1, v); check("R9", "esp write", v, 32'h7000);

        // R8 return from exception with drain wait
        rfe_req = 1; rob_empty = 0;
        step();
        rfe_req = 0;
        check("R8", "halt in wait", {30'd0, fetch_halt, flush}, 32'h2);
        // R7 faulting head during the wait is ignored
        head_valid = 1; head_done = 1; head_except = 1; head_cause = 4'd9;
        #1;
        check("R7", "no ack in wait", {31'd0, retire_ack}, 32'd0);
        step(); step();
        check("R7", "still waiting", {30'd0, fetch_halt, flush}, 32'h2);
        head_valid = 0; head_except = 0;
        rd_csr(3'd4, v); check("R7", "cause unchanged", v, 32'd0);
        rob_empty = 1;
        step();
        check("R8", "flush after drain", {30'd0, flush, fetch_halt}, 32'h3);
        check("R8", "restored pc", cur_pc, 32'h2000);
        check("R8", "restored mode", {31'd0, cur_mode}, 32'd0);
        check("R8", "restored sp", cur_sp, 32'h7000);
        check("R8", "restored flags", {28'd0, cur_flags}, 32'h3);
        step();
        check("R8", "redirect", {30'd0, redir_valid, fetch_halt}, 32'h2);
        check("R8", "redir_pc", redir_pc, 32'h2000);
        step();

        exp_mode = 0; exp_sp = 32'h7000; exp_flags = 4'h3;
        for (int k = 0; k < 4; k++) begin
            logic [3:0]  c;
            logic [31:0] tpc, taddr;
            logic [1:0]  tacc;
            logic        trfe;
            {c, tpc, taddr, tacc, trfe} = TV[k];
            exp_pc = 32'h1000 + 32'(c) * 32'h40;
            head_valid = 1; head_done = 1; head_except = 1;
            head_cause = c; head_pc = tpc; head_fault_addr = taddr; head_fault_acc = tacc;
            rfe_req = trfe;
            if (k == 2) begin csr_we = 1; csr_sel = 3'd4; csr_wdata = 32'hEE; end
            #1;
            check("R4", "fault not acked", {31'd0, retire_ack}, 32'd0);
            step();
            csr_we = 0; rfe_req = 0;
            check("R4", "flush+halt", {30'd0, flush, fetch_halt}, 32'h3);
            check("R6", "handler pc", cur_pc, exp_pc);
            check("R6", "handler sp", cur_sp, 32'hF0000 - 32'(c) * 32'h100);
            check("R6", "sup mode", {31'd0, cur_mode}, 32'd1);
            // R7 younger fault presented during the flush
            head_cause = 4'd11; head_pc = 32'hBAD;
            step();
            check("R4", "single flush", {31'd0, flush}, 32'd0);
            check("R6", "redir+release", {30'd0, redir_valid, fetch_halt}, 32'h2);
            check("R6", "redir_pc", redir_pc, exp_pc);
            head_valid = 0; head_except = 0;
            step();
            check("R10", "idle after redirect", {29'd0, redir_valid, fetch_halt, flush}, 32'd0);
            rd_csr(3'd4, v); check(k == 2 ? "R9" : "R7", "ecause", v, 32'(c));
            rd_csr(3'd0, v); check("R5", "epc", v, tpc);
            rd_csr(3'd1, v); check("R5", "esp", v, exp_sp);
            rd_csr(3'd2, v); check("R5", "eflags", v, 32'(exp_flags));
            rd_csr(3'd3, v); check("R5", "emode", v, 32'(exp_mode));
            rd_csr(3'd5, v); check("R5", "eaddr", v, taddr);
            rd_csr(3'd6, v); check("R5", "eacc", v, 32'(tacc));
            exp_mode = 1;
            exp_sp = 32'hF0000 - 32'(c) * 32'h100;
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule